// File: doc/BRIEF.md
# Write-Protect Command Sequence Decoder

This block watches the stream of byte writes (address plus data) headed for a parallel EEPROM array. It gives a verdict for each write: whether the byte may be committed to the array, or whether the write was taken as one step of a command sequence. It also holds a software protection flag. A three-write unlock sequence re-arms protection and opens a page-load window. A six-write sequence clears protection. Both changes take effect only when the programming interval ends, and that end is signalled by a one-cycle event input. While protection is set, a write that arrives without the unlock sequence is still accepted, because it still runs a dummy programming interval, but its verdict forbids the commit.

Writes enter on a valid/ready stream, and verdicts leave on a second valid/ready stream that has one register stage. Back-pressure rules: a write is accepted in any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high whenever the verdict register is empty or is being drained in that cycle. A verdict, once valid, stays unchanged until `vd_ready` takes it. The protection flag and the end-of-programming event are plain signals.

Top module: `wp_cmd_decoder`

## Requirements
- R1: During and right after reset, `prot_on` is 0 and `vd_valid` is 0.
- R2: From the idle state, the writes 0xAA to key 0x5555, 0x55 to key 0x2AAA and 0xA0 to key 0x5555 form the unlock sequence. Each of these writes gives a verdict with `vd_step`=1 and `vd_commit`=0.
- R3: After an unlock or clear sequence completes, every write up to the next `prog_done` is page data with `vd_commit`=1 and `vd_step`=0, even when it matches a key write.
- R4: `prot_on` changes only on a `prog_done` pulse. It becomes 1 if an unlock sequence completed since the previous `prog_done`, and 0 if a clear sequence completed. This holds even when no data byte followed the sequence.
- R5: The clear sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555, and each of its six writes has `vd_step`=1.
- R6: While `prot_on`=1 and no window is open, an ordinary write is accepted with `vd_commit`=0 and `vd_step`=0, and it leaves `prot_on` unchanged.
- R7: While `prot_on`=0, an ordinary write gives `vd_commit`=1.
- R8: A write that does not match the expected next step returns the matcher to idle and is judged as an ordinary write (`vd_step`=0).
- R9: Only address bits [14:0] are compared against the keys. Higher address bits do not matter.
- R10: A `prog_done` with no completed sequence leaves `prot_on` unchanged and discards a partly entered sequence.
- R11: `wr_ready` = !`vd_valid` || `vd_ready`. While `vd_valid`=1 and `vd_ready`=0, the verdict stays unchanged.
- R12: Each accepted write gives exactly one verdict, and it is valid in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | ADDR_W (17) | Write byte address |
| wr_data | input | 8 | Write data byte |
| prog_done | input | 1 | One-cycle pulse at the end of a programming interval |
| vd_valid | output | 1 | Verdict available |
| vd_ready | input | 1 | Verdict consumer ready |
| vd_commit | output | 1 | Byte may be written to the array |
| vd_step | output | 1 | Write was taken as a command-sequence step |
| prot_on | output | 1 | Software protection currently active |

## Verification
The bench builds the block with its defaults: ADDR_W = 17 over a 15-bit key compare. This puts two address bits above the keys, and the random stimulus sets them freely so that key matches with non-zero upper bits occur often. Stimulus draws mostly from the key address/data pairs, so partial, broken, complete and back-to-back sequences all appear. `prog_done` pulses and random stalls on `vd_ready` are mixed in to exercise the pending-state and back-pressure paths.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  localparam int KEY_BITS = 15;
  localparam logic [KEY_BITS-1:0] KEY_LO = 15'h5555;
  localparam logic [KEY_BITS-1:0] KEY_HI = 15'h2AAA;
  localparam logic [7:0] D_LEAD   = 8'hAA;
  localparam logic [7:0] D_SECOND = 8'h55;
  localparam logic [7:0] D_ARM    = 8'hA0;
  localparam logic [7:0] D_ESC    = 8'h80;
  localparam logic [7:0] D_CLEAR  = 8'h20;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_A1, SQ_A2, SQ_C3, SQ_C4, SQ_C5
  } seq_e;

  typedef struct packed {
    logic commit;
    logic step;
  } verdict_t;
endpackage

// File: rtl/wpd_matcher.sv
module wpd_matcher
  import wpd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              freeze,
  input  logic              clear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              step,
  output logic              arm_hit,
  output logic              clr_hit
);
  logic [KEY_BITS-1:0] key;
  logic at_lo, at_hi;
  seq_e cur, nxt;

  assign key   = addr[KEY_BITS-1:0];
  assign at_lo = (key == KEY_LO);
  assign at_hi = (key == KEY_HI);

  always_comb begin
    nxt     = SQ_IDLE;
    step    = 1'b0;
    arm_hit = 1'b0;
    clr_hit = 1'b0;
    if (!freeze) begin
      unique case (cur)
        SQ_IDLE: if (at_lo && data == D_LEAD)   begin nxt = SQ_A1; step = 1'b1; end
        SQ_A1:   if (at_hi && data == D_SECOND) begin nxt = SQ_A2; step = 1'b1; end
        SQ_A2: begin
          if (at_lo && data == D_ARM) begin
            step = 1'b1; arm_hit = 1'b1;
          end else if (at_lo && data == D_ESC) begin
            nxt = SQ_C3; step = 1'b1;
          end
        end
        SQ_C3:   if (at_lo && data == D_LEAD)   begin nxt = SQ_C4; step = 1'b1; end
        SQ_C4:   if (at_hi && data == D_SECOND) begin nxt = SQ_C5; step = 1'b1; end
        SQ_C5:   if (at_lo && data == D_CLEAR)  begin step = 1'b1; clr_hit = 1'b1; end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur <= SQ_IDLE;
    else if (clear)            cur <= SQ_IDLE;
    else if (fire && !freeze)  cur <= nxt;
  end
endmodule

// File: rtl/wpd_prot.sv
module wpd_prot (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic arm_hit,
  input  logic clr_hit,
  input  logic prog_done,
  output logic prot_on,
  output logic window_open
);
  logic pend_arm, pend_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_on     <= 1'b0;
      window_open <= 1'b0;
      pend_arm    <= 1'b0;
      pend_clr    <= 1'b0;
    end else begin
      if (prog_done) begin
        if (pend_arm)      prot_on <= 1'b1;
        else if (pend_clr) prot_on <= 1'b0;
        window_open <= 1'b0;
        pend_arm    <= 1'b0;
        pend_clr    <= 1'b0;
      end
      if (fire && arm_hit) begin
        window_open <= 1'b1;
        pend_arm    <= 1'b1;
        pend_clr    <= 1'b0;
      end else if (fire && clr_hit) begin
        window_open <= 1'b1;
        pend_arm    <= 1'b0;
        pend_clr    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpd_verdict.sv
module wpd_verdict
  import wpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  verdict_t in_vd,
  output logic     out_valid,
  input  logic     out_ready,
  output verdict_t out_vd
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vd    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_vd <= in_vd;
    end
  end
endmodule

// File: rtl/wp_cmd_decoder.sv
module wp_cmd_decoder
  import wpd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prog_done,
  output logic              vd_valid,
  input  logic              vd_ready,
  output logic              vd_commit,
  output logic              vd_step,
  output logic              prot_on
);
  logic fire, step, arm_hit, clr_hit, window_open;
  verdict_t vd_in, vd_out;

  assign fire = wr_valid && wr_ready;

  wpd_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .fire(fire), .freeze(window_open),
    .clear(prog_done), .addr(wr_addr), .data(wr_data),
    .step(step), .arm_hit(arm_hit), .clr_hit(clr_hit)
  );

  wpd_prot u_prot (
    .clk(clk), .rst_n(rst_n), .fire(fire), .arm_hit(arm_hit),
    .clr_hit(clr_hit), .prog_done(prog_done),
    .prot_on(prot_on), .window_open(window_open)
  );

  always_comb begin
    vd_in.step   = step;
    vd_in.commit = !step && (!prot_on || window_open);
  end

  wpd_verdict u_vd (
    .clk(clk), .rst_n(rst_n), .in_valid(wr_valid), .in_ready(wr_ready),
    .in_vd(vd_in), .out_valid(vd_valid), .out_ready(vd_ready), .out_vd(vd_out)
  );

  assign vd_commit = vd_out.commit;
  assign vd_step   = vd_out.step;
endmodule

module wp_cmd_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic prog_done,
  input logic vd_valid,
  input logic vd_ready,
  input logic vd_commit,
  input logic vd_step,
  input logic prot_on
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!prot_on && !vd_valid));

  assert_prot_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(prot_on));

  assert_step_never_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_step) |-> !vd_commit);

  assert_verdict_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && !vd_ready) |=> (vd_valid && $stable(vd_commit) && $stable(vd_step)));

  assert_verdict_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> vd_valid);
endmodule

bind wp_cmd_decoder wp_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .prog_done(prog_done), .vd_valid(vd_valid), .vd_ready(vd_ready),
  .vd_commit(vd_commit), .vd_step(vd_step), .prot_on(prot_on)
);

// File: tb/test_wp_cmd_decoder.sv
module test_wp_cmd_decoder;
  localparam int AW = 17;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, prog_done = 1'b0, vd_ready = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, vd_valid, vd_commit, vd_step, prot_on;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int ms = 0;
  bit m_prot = 0, m_win = 0, m_parm = 0, m_pclr = 0;
  bit last_commit = 0, last_step = 0;

  always #4 clk = ~clk;

  wp_cmd_decoder #(.ADDR_W(AW)) i_wp_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .vd_valid(vd_valid), .vd_ready(vd_ready), .vd_commit(vd_commit),
    .vd_step(vd_step), .prot_on(prot_on)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // spec model of one accepted write: returns expected step and commit
  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d,
                             output bit st, output bit cm, output string tag);
    bit lo, hi, arm, clr;
    int nx;
    lo = (a[14:0] == 15'h5555);
    hi = (a[14:0] == 15'h2AAA);
    st = 0; arm = 0; clr = 0; nx = 0;
    if (!m_win) begin
      case (ms)
        0: if (lo && d == 8'hAA) begin st = 1; nx = 1; end
        1: if (hi && d == 8'h55) begin st = 1; nx = 2; end
        2: if (lo && d == 8'hA0) begin st = 1; arm = 1; end
           else if (lo && d == 8'h80) begin st = 1; nx = 3; end
        3: if (lo && d == 8'hAA) begin st = 1; nx = 4; end
        4: if (hi && d == 8'h55) begin st = 1; nx = 5; end
        5: if (lo && d == 8'h20) begin st = 1; clr = 1; end
        default: nx = 0;
      endcase
      tag = st ? ((ms >= 3 || (ms == 2 && d == 8'h80)) ? "R5" : "R2")
               : (ms != 0 ? "R8" : (m_prot ? "R6" : "R7"));
      ms = nx;
    end else tag = "R3";
    cm = !st && (!m_prot || m_win);
    if (arm) begin m_win = 1; m_parm = 1; m_pclr = 0; end
    if (clr) begin m_win = 1; m_pclr = 1; m_parm = 0; end
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [7:0] d, input bit rnd_ready);
    bit st, cm;
    string tag;
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    #1;
    if (!wr_ready) begin
      @(negedge clk);
      chk("R11", "held valid", vd_valid, 1'b1);
      chk("R11", "held commit", vd_commit, last_commit);
      chk("R11", "held step", vd_step, last_step);
      vd_ready = 1;
      #1;
      chk("R11", "ready after drain", wr_ready, 1'b1);
    end
    model_write(a, d, st, cm, tag);
    @(negedge clk);
    wr_valid = 0;
    chk("R12", "verdict valid", vd_valid, 1'b1);
    chk(tag, "commit", vd_commit, cm);
    chk(tag, "step", vd_step, st);
    chk("R4", "prot steady on write", prot_on, m_prot);
    last_commit = cm; last_step = st;
    vd_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic done_pulse();
    string tag;
    tag = (m_parm || m_pclr) ? "R4" : "R10";
    @(negedge clk);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    if (m_parm) m_prot = 1;
    else if (m_pclr) m_prot = 0;
    m_win = 0; m_parm = 0; m_pclr = 0; ms = 0;
    chk(tag, "prot after done", prot_on, m_prot);
  endtask

  task automatic seq_arm(input logic [1:0] hb);
    put({hb, 15'h5555}, 8'hAA, 0);
    put({hb, 15'h2AAA}, 8'h55, 0);
    put({hb, 15'h5555}, 8'hA0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd91357));
    repeat (3) @(negedge clk);
    chk("R1", "prot in reset", prot_on, 1'b0);
    chk("R1", "valid in reset", vd_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "prot after reset", prot_on, 1'b0);
    chk("R1", "valid after reset", vd_valid, 1'b0);

    put(17'h00123, 8'h3C, 0);             // R7 plain write commits
    seq_arm(2'b00);                        // R2
    put(17'h00400, 8'h11, 0);              // R3 page data
    put(17'h05555, 8'hAA, 0);              // R3 key-like data inside window
    chk("R4", "prot before done", prot_on, 1'b0);
    done_pulse();                          // R4 -> 1
    put(17'h00010, 8'h77, 0);              // R6 dummy write
    done_pulse();                          // R10 unchanged
    seq_arm(2'b11);                        // R9 upper bits set
    put(17'h1F000, 8'h42, 0);              // R3
    done_pulse();
    put(17'h05555, 8'hAA, 0);              // R8 broken sequence
    put(17'h02AAA, 8'h12, 0);
    put(17'h05555, 8'hAA, 0);              // R10 partial then done
    done_pulse();
    put(17'h02AAA, 8'h55, 0);              // R8 no longer a step
    put(17'h05555, 8'hAA, 0);              // R5 clear sequence
    put(17'h02AAA, 8'h55, 0);
    put(17'h05555, 8'h80, 0);
    put(17'h05555, 8'hAA, 0);
    put(17'h02AAA, 8'h55, 0);
    put(17'h05555, 8'h20, 0);
    chk("R4", "prot held until done", prot_on, 1'b1);
    done_pulse();                          // R4 -> 0 with no data
    seq_arm(2'b01);
    done_pulse();                          // R4 -> 1 with no data

    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [1:0] hb;
      r = $urandom % 11;
      hb = 2'($urandom);
      case (r)
        0, 1: put({hb, 15'h5555}, 8'hAA, 1);
        2, 3: put({hb, 15'h2AAA}, 8'h55, 1);
        4:    put({hb, 15'h5555}, 8'hA0, 1);
        5:    put({hb, 15'h5555}, 8'h80, 1);
        6:    put({hb, 15'h5555}, 8'h20, 1);
        7:    done_pulse();
        default: put(17'($urandom), 8'($urandom), 1);
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule